// File: doc/BRIEF.md
# Streaming Byte-Wise CRC-16 Accumulator

This block runs a 16-bit cyclic redundancy check over frames of bytes. It takes one byte per clock. Each frame is marked on the input side by a start flag on its first byte and an end flag on its last byte, and a valid strobe qualifies every byte. The generator polynomial is x^16 + x^15 + x^2 + 1 (0x8005). Each byte is consumed least significant bit first. The running remainder begins at 0xFFFF for every frame. The value reported to the outside is the register with its 16 bits reversed and then complemented.

The running register feeds the eight-bit update logic directly. The bit reversal and the complement sit only on the reported result, so they never enter the loop. On a byte that carries the start flag, a seed selector replaces the stored remainder with 0xFFFF. Because of this, a new frame may begin in the cycle right after the previous frame's last byte, with no reset or idle cycle in between. One cycle after a frame's last byte is taken, the block raises a single-cycle result strobe. The finished CRC is presented with it and is held until the next frame completes.

Top module: `crc16_stream_acc`

## Requirements
- R1: For a one-byte frame (start and end flags both set), `crc_out` equals the reflected CRC-16 of that byte: polynomial 0x8005, byte taken LSB first, remainder seeded with 0xFFFF, result bit-reversed and then XORed with 0xFFFF.
- R2: The four-byte frame 0x01, 0x02, 0x03, 0x04 yields `crc_out` = 0xD45E.
- R3: `crc_valid` is high for exactly one cycle, in the cycle after a clock edge at which `in_valid` and `in_eof` are both high. It is low in every other cycle.
- R4: On clocks where `in_valid` is low, the running remainder is not changed, whatever `in_byte`, `in_sof` and `in_eof` carry. Idle cycles inside a frame do not alter its CRC.
- R5: A byte with `in_valid` and `in_sof` high is folded into 0xFFFF, not into the stored remainder. A frame may therefore start in the cycle right after the previous frame's last byte, and both CRCs are correct.
- R6: Synchronous active-high reset clears `crc_valid`, sets `crc_out` to 0x0000 and loads 0xFFFF into the remainder. Bytes taken after reset without a start flag are folded into that seed.
- R7: Frames of any length from 1 byte upward give the CRC of the whole byte sequence. The output transform never feeds back into the remainder.
- R8: `crc_out` holds its value in every cycle in which `crc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier; the remainder advances only when high |
| in_sof | input | 1 | First byte of a frame; selects the seed as fold input |
| in_eof | input | 1 | Last byte of a frame; triggers the result |
| in_byte | input | 8 | Data byte, consumed LSB first |
| crc_out | output | 16 | Reflected, complemented CRC of the last finished frame |
| crc_valid | output | 1 | One-cycle strobe, one clock after the last byte |

## Verification
A corrupted remainder stays hidden while a frame is in progress. It shows up only at the ports, one clock after the frame's end byte, as a wrong `crc_out` value together with the strobe. The bench therefore closes frames often: all 256 one-byte frames run back to back, and frames of many lengths follow, some with idle gaps. This way a bad fold term, a missing seed selection or a leak of the transform into the loop is exposed within a frame or two. Mistakes in strobe timing and output holding show up in the very next cycle, so every cycle inside and after a frame is sampled.

// File: rtl/crc16_stream_pkg.sv
`timescale 1ns/1ps
package crc16_stream_pkg;
  localparam int          DATA_W   = 8;
  localparam int          CRC_W    = 16;
  localparam logic [15:0] GEN_POLY = 16'h8005;
  localparam logic [15:0] INIT_VAL = 16'hFFFF;
  localparam logic [15:0] FINAL_XOR = 16'hFFFF;
endpackage

// File: rtl/crc_fold_bytes.sv
`timescale 1ns/1ps
// Folds DATA_W input bits, LSB first, into a non-reflected remainder:
// an unrolled chain of single-bit shift/XOR stages.
module crc_fold_bytes #(
  parameter int                CRC_W  = 16,
  parameter int                DATA_W = 8,
  parameter logic [CRC_W-1:0]  POLY   = 16'h8005
) (
  input  logic [CRC_W-1:0]  rem_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  rem_o
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = rem_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    assign fb           = stage[g][CRC_W-1] ^ data_i[g];
    assign stage[g+1]   = {stage[g][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
  end

  assign rem_o = stage[DATA_W];
endmodule

// File: rtl/crc_seed_select.sv
`timescale 1ns/1ps
// Chooses the fold input: the seed on a frame's first byte, else the stored remainder.
module crc_seed_select #(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] SEED  = 16'hFFFF
) (
  input  logic             restart_i,
  input  logic [CRC_W-1:0] stored_i,
  output logic [CRC_W-1:0] base_o
);
  always_comb begin
    base_o = restart_i ? SEED : stored_i;
  end
endmodule

// File: rtl/crc_present.sv
`timescale 1ns/1ps
// Output-side transform only: bit reversal followed by the final XOR.
module crc_present #(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] XOUT  = 16'hFFFF
) (
  input  logic [CRC_W-1:0] rem_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] flipped;

  for (genvar i = 0; i < CRC_W; i++) begin : g_rev
    assign flipped[i] = rem_i[CRC_W-1-i];
  end

  assign crc_o = flipped ^ XOUT;
endmodule

// File: rtl/crc16_stream_acc.sv
`timescale 1ns/1ps
module crc16_stream_acc #(
  parameter int                                 CRC_W  = crc16_stream_pkg::CRC_W,
  parameter int                                 DATA_W = crc16_stream_pkg::DATA_W,
  parameter logic [crc16_stream_pkg::CRC_W-1:0] POLY   = crc16_stream_pkg::GEN_POLY,
  parameter logic [crc16_stream_pkg::CRC_W-1:0] SEED   = crc16_stream_pkg::INIT_VAL,
  parameter logic [crc16_stream_pkg::CRC_W-1:0] XOUT   = crc16_stream_pkg::FINAL_XOR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_byte,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_valid
);
  localparam logic [CRC_W-1:0] OUT_RST = '0;

  logic [CRC_W-1:0] run_q;
  logic [CRC_W-1:0] fold_base;
  logic [CRC_W-1:0] fold_next;
  logic [CRC_W-1:0] shown_next;
  logic [CRC_W-1:0] res_q;
  logic             res_vld_q;
  logic             take_last;

  crc_seed_select #(.CRC_W(CRC_W), .SEED(SEED)) u_sel (
    .restart_i (in_sof),
    .stored_i  (run_q),
    .base_o    (fold_base)
  );

  crc_fold_bytes #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_fold (
    .rem_i  (fold_base),
    .data_i (in_byte),
    .rem_o  (fold_next)
  );

  crc_present #(.CRC_W(CRC_W), .XOUT(XOUT)) u_pres (
    .rem_i (fold_next),
    .crc_o (shown_next)
  );

  assign take_last = in_valid & in_eof;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= SEED;
      res_q     <= OUT_RST;
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= take_last;
      if (in_valid) begin
        run_q <= fold_next;
      end
      if (take_last) begin
        res_q <= shown_next;
      end
    end
  end

  assign crc_out   = res_q;
  assign crc_valid = res_vld_q;
endmodule

// File: rtl/crc16_stream_chk.sv
`timescale 1ns/1ps
module crc16_stream_chk #(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] SEED  = 16'hFFFF
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_eof,
  input logic             crc_valid,
  input logic [CRC_W-1:0] crc_out,
  input logic [CRC_W-1:0] run_state
);
  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof) |=> crc_valid); // R3

  AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    crc_valid |-> $past(in_valid && in_eof)); // R3

  AST_IDLE_KEEPS_REMAINDER: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(run_state)); // R4

  AST_RESET_LOADS_SEED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (run_state == SEED)); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!crc_valid && !$past(rst)) |-> $stable(crc_out)); // R8
endmodule

bind crc16_stream_acc crc16_stream_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_eof    (in_eof),
  .crc_valid (crc_valid),
  .crc_out   (crc_out),
  .run_state (run_q)
);

// File: tb/crc16_stream_acc_tb_top.sv
`timescale 1ns/1ps
module crc16_stream_acc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [15:0] crc_out;
  logic        crc_valid;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  logic [7:0] fbuf [0:63];

  always #2 clk = ~clk;

  crc16_stream_acc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_byte(in_byte), .crc_out(crc_out), .crc_valid(crc_valid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
    end
  endtask

  // Reflected-register form: shift right, polynomial 0x8005 reversed is 0xA001.
  function automatic logic [15:0] model_crc(input int n);
    logic [15:0] r = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        if ((r[0] ^ fbuf[k][b]) == 1'b1) r = (r >> 1) ^ 16'hA001;
        else                             r = r >> 1;
      end
    end
    return ~r;
  endfunction

  task automatic go_idle();
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // Starts and ends at a negedge; drives fbuf[0..n-1] as one frame.
  task automatic run_frame(input int n, input bit gaps, input bit use_sof,
                           input string req, input logic [15:0] exp);
    for (int k = 0; k < n; k++) begin
      if (gaps && (k % 2 == 1)) begin
        in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_byte = ~fbuf[k];
        @(posedge clk); @(negedge clk);
        chk("R4 idle strobe", {15'd0, crc_valid}, 16'd0);
      end
      in_valid = 1'b1;
      in_sof   = use_sof && (k == 0);
      in_eof   = (k == n - 1);
      in_byte  = fbuf[k];
      @(posedge clk); @(negedge clk);
      if (k < n - 1) chk("R3 no early strobe", {15'd0, crc_valid}, 16'd0);
    end
    chk({req, " strobe"}, {15'd0, crc_valid}, 16'd1);
    chk(req, crc_out, exp);
    go_idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: reset state
    chk("R6 reset crc_out", crc_out, 16'h0000);
    chk("R6 reset strobe", {15'd0, crc_valid}, 16'd0);

    // R2: known vector
    fbuf[0] = 8'h01; fbuf[1] = 8'h02; fbuf[2] = 8'h03; fbuf[3] = 8'h04;
    run_frame(4, 1'b0, 1'b1, "R2 known vector", 16'hD45E);
    held = crc_out;
    // R3/R8: one-cycle strobe and held result
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 strobe width", {15'd0, crc_valid}, 16'd0);
      chk("R8 result held", crc_out, held);
    end

    // R1/R5: every byte as a one-byte frame, back to back
    for (int b = 0; b < 256; b++) begin
      fbuf[0] = b[7:0];
      run_frame(1, 1'b0, 1'b1, "R1 single byte", model_crc(1));
    end

    // R4: gaps with junk on data/sof/eof
    for (int k = 0; k < 9; k++) fbuf[k] = 8'(k * 29 + 7);
    run_frame(9, 1'b1, 1'b1, "R4 gapped frame", model_crc(9));

    // R5: frame immediately followed by another with sof
    for (int k = 0; k < 3; k++) fbuf[k] = 8'(8'hA5 ^ k);
    run_frame(3, 1'b0, 1'b1, "R5 frame A", model_crc(3));
    for (int k = 0; k < 5; k++) fbuf[k] = 8'(k * 53 + 1);
    run_frame(5, 1'b0, 1'b1, "R5 frame B", model_crc(5));

    // R6: reset mid-frame, then frame without sof starts from seed
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_byte = 8'h3C;
    @(posedge clk); @(negedge clk);
    go_idle(); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R6 reset clears out", crc_out, 16'h0000);
    chk("R6 reset clears strobe", {15'd0, crc_valid}, 16'd0);
    for (int k = 0; k < 4; k++) fbuf[k] = 8'(k * 17 + 200);
    run_frame(4, 1'b0, 1'b0, "R6 seeded after reset", model_crc(4));

    // R7: many lengths, some gapped
    for (int f = 0; f < 40; f++) begin
      int len = (f % 20) + 1;
      for (int k = 0; k < len; k++) fbuf[k] = 8'((f * 91 + k * 37 + (k * k)) ^ (f << 3));
      run_frame(len, f[0], 1'b1, "R7 long frame", model_crc(len));
    end

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule